// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block walks a small LCD panel controller through its register-level power-up and power-down scripts. It does not drive the serial link itself. It hands one register write at a time to a separate serial writer, over a request/done handshake, and it moves to the next step only after the writer reports that the current one has gone out. The steps live in a computed ROM. The power-up part of the ROM begins with three bare wake-up commands, and each of them is followed by a pause from a down-counter. The power-down part is a short four-step script of its own.

A host pulses `start_req` to bring the panel up and `stop_req` to take it down. `pwr_state` always reports one of four phases. A request that arrives while a script is running is held and acted on when that script ends. A request that asks for the phase the block is already in is dropped.

States of the control machine are as follows.
- `ST_OFF` reports off.
- `ST_UP_WRITE` and `ST_UP_PAUSE` report starting.
- `ST_LIVE` reports active.
- `ST_DOWN_WRITE` reports stopping.

Transitions between the states are as follows.
- OFF goes to UP_WRITE on a start request, whether it is fresh or held.
- UP_WRITE goes to UP_PAUSE when the writer reports done on a step flagged for a pause.
- UP_PAUSE goes back to UP_WRITE on the next step when the timer expires.
- UP_WRITE goes to LIVE when the writer reports done on the last power-up step.
- LIVE goes to DOWN_WRITE on a stop request, whether it is fresh or held.
- DOWN_WRITE goes to OFF when the writer reports done on the last power-down step.
- In every other case UP_WRITE and DOWN_WRITE advance to the next step when the writer reports done.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is asserted and directly after it, `pwr_state` is 0 (off) and `wr_valid` is low.
- R2: A write request stays valid with `wr_cmd`, `wr_len` and `wr_data` stable until `wr_done` is seen. The next step is presented only after that. `wr_len` gives the number of data bytes: 0 means a bare command, 1 means the byte in `wr_data[7:0]`, and 2 means `wr_data[15:0]` sent high byte first. `wr_len` is never 3.
- R3: Power-up opens with command 0x00 sent three times with `wr_len` = 0. After the done of each of them, `wr_valid` stays low for PAUSE_CYCLES cycles. The next request therefore appears PAUSE_CYCLES+1 cycles after the done is driven. The default of PAUSE_CYCLES is CLK_HZ/1000, which is 1 ms.
- R4: Next in power-up come the following steps, as (command, length, value), in this order: (0xB0,1,0x17) to leave deep standby, (0xBC,1,0x80), (0x3B,1,0x00), (0xB0,1,0x16) to enable the analog supplies, (0xB8,2,0xFFF9), and then the bare command 0x11 to wake from sleep.
- R5: The rest of power-up, in order: BA=01, BB=00, 3A=60, BF=10, B1=56, B2=33, B3=11, B3=11, B4=02, B5=2B, B6=40, B7=03, B9=04, BD=04, BE=00, C0=11, C1=11, C2=11, C3=2040, C4=60C0, C5=1020, C6=60C0, C7=5533, C8=00, C9=00, CA=00, EC=01F0, CF=02, D0=0804, D1=01, D2=0000, D3=0D0E, D4=11A4, D5=0E. Four-digit values use length 2 and two-digit values use length 1. The script ends with the bare command 0x29.
- R6: `pwr_state` encodes 0 as off, 1 as starting, 2 as active and 3 as stopping. It reads 1 in the cycle after a start request is accepted. It reads 1 during every power-up write, and it turns to 2 only after the done of the final 0x29.
- R7: Power-down sends these steps in order: the bare command 0x28, then (0xB8,2,0x8002), then the bare command 0x10, then (0xB0,1,0x00). `pwr_state` reads 3 throughout and returns to 0 only after the last done.
- R8: A start request while active and a stop request while off cause no write and no change of `pwr_state`.
- R9: Requests that arrive while starting or stopping are held and acted on once the script completes. A later request replaces an earlier one, and a stop wins when both arrive in the same cycle. A held stop moves the block from active to stopping after one active cycle. A held start moves it from off to starting after one off cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Single-cycle power-up request |
| stop_req | input | 1 | Single-cycle power-down request |
| wr_done | input | 1 | Writer reports the current step sent |
| pwr_state | output | 2 | 0 off, 1 starting, 2 active, 3 stopping |
| wr_valid | output | 1 | A write step is being requested |
| wr_cmd | output | 8 | Command / register byte |
| wr_len | output | 2 | Number of data bytes (0..2) |
| wr_data | output | 16 | Data value, meaning set by `wr_len` |

## Verification
The assertions assume that the writer pulses `wr_done` for a single cycle, and only while `wr_valid` is high. They also assume one done per step, with no done during a pause. The bench's writer model follows that discipline. It watches `wr_valid` at the falling edge, waits a chosen latency, raises done for exactly one cycle, and drops it before it looks at the next step. Start and stop requests are one-cycle pulses that the bench places on falling edges. This includes pulses that land in the middle of a running script, which exercise the held-request path.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        PWR_OFF      = 2'd0,
        PWR_STARTING = 2'd1,
        PWR_ACTIVE   = 2'd2,
        PWR_STOPPING = 2'd3
    } pwr_phase_e;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [1:0]  len;
        logic [15:0] value;
        logic        pause;
    } step_t;

    localparam int UP_STEPS   = 44;
    localparam int DOWN_STEPS = 4;
    localparam int ALL_STEPS  = UP_STEPS + DOWN_STEPS;
    localparam int IDX_W      = $clog2(ALL_STEPS);

    function automatic step_t mk_step(logic [7:0] c, logic [1:0] n,
                                      logic [15:0] v, logic p);
        step_t s;
        s.cmd   = c;
        s.len   = n;
        s.value = v;
        s.pause = p;
        return s;
    endfunction

endpackage

// File: rtl/lps_script_rom.sv
module lps_script_rom
    import lps_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // Power-up occupies 0..UP_STEPS-1, power-down follows it.
    always_comb begin
        step = '0;
        unique case (idx)
            6'd0:  step = mk_step(8'h00, 2'd0, 16'h0000, 1'b1);
            6'd1:  step = mk_step(8'h00, 2'd0, 16'h0000, 1'b1);
            6'd2:  step = mk_step(8'h00, 2'd0, 16'h0000, 1'b1);
            6'd3:  step = mk_step(8'hB0, 2'd1, 16'h0017, 1'b0);
            6'd4:  step = mk_step(8'hBC, 2'd1, 16'h0080, 1'b0);
            6'd5:  step = mk_step(8'h3B, 2'd1, 16'h0000, 1'b0);
            6'd6:  step = mk_step(8'hB0, 2'd1, 16'h0016, 1'b0);
            6'd7:  step = mk_step(8'hB8, 2'd2, 16'hFFF9, 1'b0);
            6'd8:  step = mk_step(8'h11, 2'd0, 16'h0000, 1'b0);
            6'd9:  step = mk_step(8'hBA, 2'd1, 16'h0001, 1'b0);
            6'd10: step = mk_step(8'hBB, 2'd1, 16'h0000, 1'b0);
            6'd11: step = mk_step(8'h3A, 2'd1, 16'h0060, 1'b0);
            6'd12: step = mk_step(8'hBF, 2'd1, 16'h0010, 1'b0);
            6'd13: step = mk_step(8'hB1, 2'd1, 16'h0056, 1'b0);
            6'd14: step = mk_step(8'hB2, 2'd1, 16'h0033, 1'b0);
            6'd15: step = mk_step(8'hB3, 2'd1, 16'h0011, 1'b0);
            6'd16: step = mk_step(8'hB3, 2'd1, 16'h0011, 1'b0);
            6'd17: step = mk_step(8'hB4, 2'd1, 16'h0002, 1'b0);
            6'd18: step = mk_step(8'hB5, 2'd1, 16'h002B, 1'b0);
            6'd19: step = mk_step(8'hB6, 2'd1, 16'h0040, 1'b0);
            6'd20: step = mk_step(8'hB7, 2'd1, 16'h0003, 1'b0);
            6'd21: step = mk_step(8'hB9, 2'd1, 16'h0004, 1'b0);
            6'd22: step = mk_step(8'hBD, 2'd1, 16'h0004, 1'b0);
            6'd23: step = mk_step(8'hBE, 2'd1, 16'h0000, 1'b0);
            6'd24: step = mk_step(8'hC0, 2'd1, 16'h0011, 1'b0);
            6'd25: step = mk_step(8'hC1, 2'd1, 16'h0011, 1'b0);
            6'd26: step = mk_step(8'hC2, 2'd1, 16'h0011, 1'b0);
            6'd27: step = mk_step(8'hC3, 2'd2, 16'h2040, 1'b0);
            6'd28: step = mk_step(8'hC4, 2'd2, 16'h60C0, 1'b0);
            6'd29: step = mk_step(8'hC5, 2'd2, 16'h1020, 1'b0);
            6'd30: step = mk_step(8'hC6, 2'd2, 16'h60C0, 1'b0);
            6'd31: step = mk_step(8'hC7, 2'd2, 16'h5533, 1'b0);
            6'd32: step = mk_step(8'hC8, 2'd1, 16'h0000, 1'b0);
            6'd33: step = mk_step(8'hC9, 2'd1, 16'h0000, 1'b0);
            6'd34: step = mk_step(8'hCA, 2'd1, 16'h0000, 1'b0);
            6'd35: step = mk_step(8'hEC, 2'd2, 16'h01F0, 1'b0);
            6'd36: step = mk_step(8'hCF, 2'd1, 16'h0002, 1'b0);
            6'd37: step = mk_step(8'hD0, 2'd2, 16'h0804, 1'b0);
            6'd38: step = mk_step(8'hD1, 2'd1, 16'h0001, 1'b0);
            6'd39: step = mk_step(8'hD2, 2'd2, 16'h0000, 1'b0);
            6'd40: step = mk_step(8'hD3, 2'd2, 16'h0D0E, 1'b0);
            6'd41: step = mk_step(8'hD4, 2'd2, 16'h11A4, 1'b0);
            6'd42: step = mk_step(8'hD5, 2'd1, 16'h000E, 1'b0);
            6'd43: step = mk_step(8'h29, 2'd0, 16'h0000, 1'b0);
            6'd44: step = mk_step(8'h28, 2'd0, 16'h0000, 1'b0);
            6'd45: step = mk_step(8'hB8, 2'd2, 16'h8002, 1'b0);
            6'd46: step = mk_step(8'h10, 2'd0, 16'h0000, 1'b0);
            6'd47: step = mk_step(8'hB0, 2'd1, 16'h0000, 1'b0);
            default: step = '0;
        endcase
    end

endmodule

// File: rtl/lps_pause_timer.sv
module lps_pause_timer #(
    parameter int CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic expired
);

    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= LOAD;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign busy    = run;
    assign expired = run && (cnt == '0);

    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);                                           // R3
    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= LOAD);                                      // R3

endmodule

// File: rtl/lps_req_hold.sv
module lps_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic start_req,
    input  logic stop_req,
    output logic pend_start,
    output logic pend_stop
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_start <= 1'b0;
            pend_stop  <= 1'b0;
        end else if (!busy) begin
            pend_start <= 1'b0;
            pend_stop  <= 1'b0;
        end else if (stop_req) begin
            pend_start <= 1'b0;
            pend_stop  <= 1'b1;
        end else if (start_req) begin
            pend_start <= 1'b1;
            pend_stop  <= 1'b0;
        end
    end

    AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_start, pend_stop}));                        // R9

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lps_pkg::*;
#(
    parameter int CLK_HZ       = 125_000_000,
    parameter int PAUSE_CYCLES = CLK_HZ / 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        stop_req,
    input  logic        wr_done,
    output logic [1:0]  pwr_state,
    output logic        wr_valid,
    output logic [7:0]  wr_cmd,
    output logic [1:0]  wr_len,
    output logic [15:0] wr_data
);

    localparam logic [IDX_W-1:0] UP_LAST    = IDX_W'(UP_STEPS - 1);
    localparam logic [IDX_W-1:0] DOWN_FIRST = IDX_W'(UP_STEPS);
    localparam logic [IDX_W-1:0] DOWN_LAST  = IDX_W'(ALL_STEPS - 1);

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP_WRITE,
        ST_UP_PAUSE,
        ST_LIVE,
        ST_DOWN_WRITE
    } seq_state_e;

    seq_state_e       state, state_nxt;
    logic [IDX_W-1:0] idx, idx_nxt;
    step_t            step;
    logic             tmr_start, tmr_busy, tmr_expired;
    logic             pend_start, pend_stop, busy;
    pwr_phase_e       phase;

    lps_script_rom u_rom (
        .idx  (idx),
        .step (step)
    );

    lps_pause_timer #(.CYCLES(PAUSE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .busy    (tmr_busy),
        .expired (tmr_expired)
    );

    assign busy = (state == ST_UP_WRITE) || (state == ST_UP_PAUSE) ||
                  (state == ST_DOWN_WRITE);

    lps_req_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .pend_start (pend_start),
        .pend_stop  (pend_stop)
    );

    // Next-state and step index
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        tmr_start = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (start_req || pend_start) begin
                    state_nxt = ST_UP_WRITE;
                    idx_nxt   = '0;
                end
            end
            ST_UP_WRITE: begin
                if (wr_done) begin
                    if (step.pause) begin
                        state_nxt = ST_UP_PAUSE;
                        tmr_start = 1'b1;
                    end else if (idx == UP_LAST) begin
                        state_nxt = ST_LIVE;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            ST_UP_PAUSE: begin
                if (tmr_expired) begin
                    state_nxt = ST_UP_WRITE;
                    idx_nxt   = idx + 1'b1;
                end
            end
            ST_LIVE: begin
                if (stop_req || pend_stop) begin
                    state_nxt = ST_DOWN_WRITE;
                    idx_nxt   = DOWN_FIRST;
                end
            end
            ST_DOWN_WRITE: begin
                if (wr_done) begin
                    if (idx == DOWN_LAST) state_nxt = ST_OFF;
                    else                  idx_nxt   = idx + 1'b1;
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    // Outputs
    always_comb begin
        phase    = PWR_OFF;
        wr_valid = 1'b0;
        unique case (state)
            ST_OFF:        phase = PWR_OFF;
            ST_UP_WRITE: begin
                phase    = PWR_STARTING;
                wr_valid = 1'b1;
            end
            ST_UP_PAUSE:   phase = PWR_STARTING;
            ST_LIVE:       phase = PWR_ACTIVE;
            ST_DOWN_WRITE: begin
                phase    = PWR_STOPPING;
                wr_valid = 1'b1;
            end
            default:       phase = PWR_OFF;
        endcase
        wr_cmd  = wr_valid ? step.cmd   : 8'h00;
        wr_len  = wr_valid ? step.len   : 2'd0;
        wr_data = wr_valid ? step.value : 16'h0000;
    end

    assign pwr_state = phase;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_cmd) &&
                                    $stable(wr_len) && $stable(wr_data)));   // R2
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != 2'd3));                                      // R2
    AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !wr_valid);                                             // R3
    AST_LIVE_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_ACTIVE && $past(pwr_state) != PWR_ACTIVE) |->
        $past(wr_done && wr_valid && wr_cmd == 8'h29));                      // R6
    AST_OFF_AFTER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_OFF && $past(pwr_state) == PWR_STOPPING) |->
        $past(wr_done && wr_cmd == 8'hB0 && wr_data == 16'h0000));           // R7
    AST_ACTIVE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_ACTIVE) |=>
        (pwr_state == PWR_ACTIVE || pwr_state == PWR_STOPPING));             // R8
    AST_OFF_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_OFF) |=>
        (pwr_state == PWR_OFF || pwr_state == PWR_STARTING));                // R8

endmodule

// File: tb/lcd_pwr_seq_tb_top.sv
module lcd_pwr_seq_tb_top;
    timeunit 1ns;
    timeprecision 1ps;
    import lps_pkg::*;

    localparam int PAUSE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        wr_done = 1'b0;
    logic [1:0]  pwr_state;
    logic        wr_valid;
    logic [7:0]  wr_cmd;
    logic [1:0]  wr_len;
    logic [15:0] wr_data;

    int    n_cmp = 0, n_bad = 0, cyc = 0, lat = 0, writes = 0;
    bit    summary_done = 1'b0;
    step_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_pwr_seq #(.CLK_HZ(125_000_000), .PAUSE_CYCLES(PAUSE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .wr_done   (wr_done),
        .pwr_state (pwr_state),
        .wr_valid  (wr_valid),
        .wr_cmd    (wr_cmd),
        .wr_len    (wr_len),
        .wr_data   (wr_data)
    );

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push(logic [7:0] c, logic [1:0] n, logic [15:0] v, string tag);
        exp_q.push_back(mk_step(c, n, v, (tag == "R3")));
        tag_q.push_back(tag);
    endtask

    task automatic load_up();
        for (int i = 0; i < 3; i++) push(8'h00, 2'd0, 16'h0000, "R3");
        push(8'hB0, 1, 16'h17, "R4"); push(8'hBC, 1, 16'h80, "R4");
        push(8'h3B, 1, 16'h00, "R4"); push(8'hB0, 1, 16'h16, "R4");
        push(8'hB8, 2, 16'hFFF9, "R4"); push(8'h11, 0, 16'h0, "R4");
        push(8'hBA, 1, 16'h01, "R5"); push(8'hBB, 1, 16'h00, "R5");
        push(8'h3A, 1, 16'h60, "R5"); push(8'hBF, 1, 16'h10, "R5");
        push(8'hB1, 1, 16'h56, "R5"); push(8'hB2, 1, 16'h33, "R5");
        push(8'hB3, 1, 16'h11, "R5"); push(8'hB3, 1, 16'h11, "R5");
        push(8'hB4, 1, 16'h02, "R5"); push(8'hB5, 1, 16'h2B, "R5");
        push(8'hB6, 1, 16'h40, "R5"); push(8'hB7, 1, 16'h03, "R5");
        push(8'hB9, 1, 16'h04, "R5"); push(8'hBD, 1, 16'h04, "R5");
        push(8'hBE, 1, 16'h00, "R5"); push(8'hC0, 1, 16'h11, "R5");
        push(8'hC1, 1, 16'h11, "R5"); push(8'hC2, 1, 16'h11, "R5");
        push(8'hC3, 2, 16'h2040, "R5"); push(8'hC4, 2, 16'h60C0, "R5");
        push(8'hC5, 2, 16'h1020, "R5"); push(8'hC6, 2, 16'h60C0, "R5");
        push(8'hC7, 2, 16'h5533, "R5"); push(8'hC8, 1, 16'h00, "R5");
        push(8'hC9, 1, 16'h00, "R5"); push(8'hCA, 1, 16'h00, "R5");
        push(8'hEC, 2, 16'h01F0, "R5"); push(8'hCF, 1, 16'h02, "R5");
        push(8'hD0, 2, 16'h0804, "R5"); push(8'hD1, 1, 16'h01, "R5");
        push(8'hD2, 2, 16'h0000, "R5"); push(8'hD3, 2, 16'h0D0E, "R5");
        push(8'hD4, 2, 16'h11A4, "R5"); push(8'hD5, 1, 16'h0E, "R5");
        push(8'h29, 0, 16'h0, "R5");
    endtask

    task automatic load_down();
        push(8'h28, 0, 16'h0, "R7"); push(8'hB8, 2, 16'h8002, "R7");
        push(8'h10, 0, 16'h0, "R7"); push(8'hB0, 1, 16'h00, "R7");
    endtask

    // Writer model and scoreboard monitor
    bit    pv = 1'b0, gap_pending = 1'b0;
    int    done_cyc = 0, wcnt = 0;
    logic [7:0] first_cmd = 8'h00;
    step_t e;
    string t;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && (!pv || wr_done)) begin
                first_cmd = wr_cmd;
                if (gap_pending) begin
                    check((cyc - done_cyc) == PAUSE + 1, "R3", "pause gap",
                          cyc - done_cyc, PAUSE + 1);
                    gap_pending = 1'b0;
                end
            end
            if (wr_done) begin
                wr_done = 1'b0;
            end else if (wr_valid) begin
                if (wcnt >= lat) begin
                    writes++;
                    check(wr_cmd == first_cmd, "R2", "held cmd", wr_cmd, first_cmd);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected write", wr_cmd, 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(wr_cmd == e.cmd, t, "cmd", wr_cmd, e.cmd);
                        check(wr_len == e.len, t, "len", wr_len, e.len);
                        check(wr_data == e.value, t, "data", wr_data, e.value);
                        check(pwr_state == ((t == "R7") ? 2'd3 : 2'd1), "R6",
                              "state during write", pwr_state,
                              (t == "R7") ? 3 : 1);
                        if (e.pause) begin
                            gap_pending = 1'b1;
                            done_cyc = cyc;
                        end
                    end
                    wr_done = 1'b1;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
            pv = wr_valid;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
    endtask

    task automatic wait_state(logic [1:0] s, string tag);
        for (int i = 0; i < 5000; i++) begin
            if (pwr_state == s) break;
            @(negedge clk);
        end
        check(pwr_state == s, tag, "reach state", pwr_state, s);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        check(pwr_state == 2'd0, "R1", "reset state", pwr_state, 0);
        check(wr_valid == 1'b0, "R1", "reset valid", wr_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwr_state == 2'd0 && !wr_valid, "R1", "after reset", pwr_state, 0);

        // Stop while off is dropped
        pulse_stop();
        repeat (20) @(negedge clk);
        check(pwr_state == 2'd0, "R8", "stop while off", pwr_state, 0);
        check(writes == 0, "R8", "writes after stop while off", writes, 0);

        // Full power-up with immediate done
        load_up();
        pulse_start();
        check(pwr_state == 2'd1, "R6", "starting after request", pwr_state, 1);
        wait_state(2'd2, "R6");
        check(exp_q.size() == 0, "R5", "power-up script consumed", exp_q.size(), 0);

        // Start while active is dropped
        w = writes;
        pulse_start();
        repeat (20) @(negedge clk);
        check(pwr_state == 2'd2, "R8", "start while active", pwr_state, 2);
        check(writes == w, "R8", "writes after start while active", writes, w);

        // Power-down
        load_down();
        pulse_stop();
        check(pwr_state == 2'd3, "R7", "stopping after request", pwr_state, 3);
        wait_state(2'd0, "R7");
        check(exp_q.size() == 0, "R7", "power-down script consumed", exp_q.size(), 0);

        // Held stop during power-up, slower writer
        lat = 3;
        load_up();
        load_down();
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_stop();
        wait_state(2'd2, "R9");
        @(negedge clk);
        check(pwr_state == 2'd3, "R9", "held stop acted on", pwr_state, 3);
        wait_state(2'd0, "R9");
        check(exp_q.size() == 0, "R9", "scripts after held stop", exp_q.size(), 0);

        // Later start replaces an earlier stop while starting
        load_up();
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_stop();
        repeat (5) @(negedge clk);
        pulse_start();
        wait_state(2'd2, "R9");
        repeat (20) @(negedge clk);
        check(pwr_state == 2'd2, "R9", "later start replaced stop", pwr_state, 2);
        check(exp_q.size() == 0, "R9", "no extra writes", exp_q.size(), 0);

        // Held start during power-down
        load_down();
        pulse_stop();
        repeat (3) @(negedge clk);
        pulse_start();
        load_up();
        wait_state(2'd0, "R9");
        @(negedge clk);
        check(pwr_state == 2'd1, "R9", "held start acted on", pwr_state, 1);
        wait_state(2'd2, "R9");
        check(exp_q.size() == 0, "R9", "scripts after held start", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule